// File: doc/BRIEF.md
# Next Fetch Address Unit with Branch Target Buffer

This fetch-stage block chooses, every clock, the address the front end fetches next. It looks up the current fetch address in a small direct-mapped branch target buffer (BTB). A hit marks the fetched instruction as a branch. If a separate direction predictor also says "taken", the block steers fetch to the target that this branch jumped to the last time it ran. Otherwise fetch moves on to the sequential address, the fetch address plus the fixed instruction size. The direction input may be tied high for a plain always-taken policy, which needs no direction predictor at all.

Branch resolution in execute drives an update port with the branch address, its actual target, its outcome and a mispredict flag. A resolved taken branch writes its entry with a tag and the actual target. A mispredict takes priority over the prediction: it steers fetch onto the correct path and raises a one-cycle flush, which tells the younger stages to drop their wrong-path instructions. Each wrong guess therefore costs the pipeline its bubbles, and a correct guess costs nothing. Every output is registered, so each one reflects the inputs sampled at the previous rising edge.

Top module: `fetch_target_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every entry becomes invalid and the next outputs are `next_pc`=0, `btb_hit`=0 and `flush`=0. After reset, every lookup misses until a taken branch is resolved.
- R2: `next_pc`, `btb_hit` and `flush` are registered. Each one reflects the inputs sampled at the immediately preceding rising edge.
- R3: A lookup hits when the entry at index `fetch_pc[OFS_W+IDX_W-1:OFS_W]` is valid and its tag equals `fetch_pc[ADDR_W-1:OFS_W+IDX_W]`, where OFS_W=log2(INSN_BYTES) and IDX_W=log2(ENTRIES) (bits [5:2] and [31:6] by default). The bits below OFS_W play no part in the lookup. An address that shares an index but carries a different tag misses.
- R4: With no redirect, `next_pc` is the stored target when the lookup hits and `dir_taken`=1. Otherwise it is `fetch_pc + INSN_BYTES`. `btb_hit` reports the lookup result.
- R5: With `dir_taken` held at 1, every hit steers fetch to the stored target.
- R6: When `resolve_valid`=1 and `resolve_taken`=1, the entry for `resolve_pc` is written with its tag and `resolve_target` and marked valid. This replaces whatever that index held before, so the latest dynamic instance of the branch wins and an aliasing branch evicts the older one.
- R7: A resolution with `resolve_taken`=0 leaves the BTB unchanged.
- R8: When `resolve_valid`=1 and `resolve_mispredict`=1, `next_pc` becomes `resolve_target` if `resolve_taken`=1, or `resolve_pc + INSN_BYTES` if it is 0. This wins over any prediction made in the same cycle, and `flush` is 1 for exactly that cycle. At all other times `flush` is 0.
- R9: When a lookup and an update hit the same index in one cycle, the lookup uses the entry as it was before the update. The new contents are visible from the next cycle on.
- R10: With `resolve_valid`=0, the `resolve_taken` and `resolve_mispredict` inputs neither redirect, nor flush, nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address fetched this cycle |
| dir_taken | input | 1 | Direction guess from the direction predictor (may be tied to 1) |
| resolve_valid | input | 1 | A branch resolves this cycle |
| resolve_pc | input | ADDR_W | Address of the resolving branch |
| resolve_target | input | ADDR_W | Actual target of the resolving branch |
| resolve_taken | input | 1 | Actual outcome of the resolving branch |
| resolve_mispredict | input | 1 | The earlier guess for this branch was wrong |
| next_pc | output | ADDR_W | Registered next fetch address |
| btb_hit | output | 1 | Registered lookup hit, meaning the fetched instruction is treated as a branch |
| flush | output | 1 | Registered one-cycle request to drop younger stages |

## Verification
Two functions can fall in the same cycle. The first is a mispredict redirect arriving while the current fetch address hits a taken entry. The second is an update writing the very index that is being looked up. The bench provokes the first by resolving a mispredicted branch while fetching an address already held in the BTB, and judges that `next_pc` takes the correct-path address and `flush` rises while `btb_hit` still reports the lookup. It provokes the second by resolving a new taken branch at the address being fetched, and judges a miss in that cycle and a hit with the new target in the next. A behavioural model checks all three outputs on every clock, first through directed phases and then through a randomized mix over a narrow address range, which makes such collisions and aliasing frequent.

// File: rtl/fta_pkg.sv
package fta_pkg;

  // Source of the registered next fetch address
  typedef enum logic [1:0] {
    SRC_SEQ     = 2'd0,
    SRC_BTB     = 2'd1,
    SRC_FIX_TGT = 2'd2,
    SRC_FIX_SEQ = 2'd3
  } npc_src_e;

endpackage

// File: rtl/fta_addr_split.sv
module fta_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  // the bits below OFS_W are alignment only and take no part in the lookup
  assign idx = addr[OFS_W +: IDX_W];
  assign tag = addr[ADDR_W-1 : OFS_W+IDX_W];

endmodule

// File: rtl/fta_btb_store.sv
module fta_btb_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_tgt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt
);

  // Tag and target arrays carry no reset, so they fit distributed RAM
  logic [TAG_W-1:0]  tag_mem [ENTRIES];
  logic [ADDR_W-1:0] tgt_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  // Valid bits carry a synchronous reset, one flop per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst)
        vld[e] <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(e)))
        vld[e] <= 1'b1;
    end
  end

  // the read port is asynchronous, so it sees the contents before any same-cycle write
  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_tgt   = tgt_mem[rd_idx];

endmodule

// File: rtl/fta_next_sel.sv
module fta_next_sel
  import fta_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_tgt,
  input  logic              dir_taken,
  input  logic              fix_en,
  input  logic              fix_taken,
  input  logic [ADDR_W-1:0] fix_pc,
  input  logic [ADDR_W-1:0] fix_tgt,
  output logic [ADDR_W-1:0] next_pc,
  output logic              btb_hit,
  output logic              flush
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  npc_src_e          src;
  logic [ADDR_W-1:0] npc_d;

  // a redirect wins over the prediction
  always_comb begin
    if (fix_en)
      src = fix_taken ? SRC_FIX_TGT : SRC_FIX_SEQ;
    else if (hit && dir_taken)
      src = SRC_BTB;
    else
      src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_BTB:     npc_d = hit_tgt;
      SRC_FIX_TGT: npc_d = fix_tgt;
      SRC_FIX_SEQ: npc_d = fix_pc + STEP;
      default:     npc_d = fetch_pc + STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc <= '0;
      btb_hit <= 1'b0;
      flush   <= 1'b0;
    end else begin
      next_pc <= npc_d;
      btb_hit <= hit;
      flush   <= fix_en;
    end
  end

endmodule

// File: rtl/fetch_target_unit.sv
module fetch_target_unit #(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              dir_taken,
  input  logic              resolve_valid,
  input  logic [ADDR_W-1:0] resolve_pc,
  input  logic [ADDR_W-1:0] resolve_target,
  input  logic              resolve_taken,
  input  logic              resolve_mispredict,
  output logic [ADDR_W-1:0] next_pc,
  output logic              btb_hit,
  output logic              flush
);

  localparam int OFS_W = $clog2(INSN_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic [IDX_W-1:0]  look_idx, upd_idx;
  logic [TAG_W-1:0]  look_tag, upd_tag;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_tgt;
  logic              hit;
  logic              wr_en;
  logic              fix_en;

  fta_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) split_look_i (
    .addr (fetch_pc),
    .idx  (look_idx),
    .tag  (look_tag)
  );

  fta_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) split_upd_i (
    .addr (resolve_pc),
    .idx  (upd_idx),
    .tag  (upd_tag)
  );

  assign wr_en  = resolve_valid && resolve_taken;
  assign fix_en = resolve_valid && resolve_mispredict;

  fta_btb_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (look_idx),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_tgt   (ent_tgt),
    .wr_en    (wr_en),
    .wr_idx   (upd_idx),
    .wr_tag   (upd_tag),
    .wr_tgt   (resolve_target)
  );

  assign hit = ent_valid && (ent_tag == look_tag);

  fta_next_sel #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) sel_i (
    .clk       (clk),
    .rst       (rst),
    .fetch_pc  (fetch_pc),
    .hit       (hit),
    .hit_tgt   (ent_tgt),
    .dir_taken (dir_taken),
    .fix_en    (fix_en),
    .fix_taken (resolve_taken),
    .fix_pc    (resolve_pc),
    .fix_tgt   (resolve_target),
    .next_pc   (next_pc),
    .btb_hit   (btb_hit),
    .flush     (flush)
  );

endmodule

// File: rtl/fta_checker.sv
module fta_checker #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              dir_taken,
  input logic              resolve_valid,
  input logic [ADDR_W-1:0] resolve_pc,
  input logic [ADDR_W-1:0] resolve_target,
  input logic              resolve_taken,
  input logic              resolve_mispredict,
  input logic [ADDR_W-1:0] next_pc,
  input logic              btb_hit,
  input logic              flush
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  a_r8_flush_on_fix: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && resolve_mispredict) |=> flush);

  a_r10_no_flush_idle: assert property (@(posedge clk) disable iff (rst)
    !(resolve_valid && resolve_mispredict) |=> !flush);

  a_r8_fix_target: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && resolve_mispredict && resolve_taken) |=> next_pc == $past(resolve_target));

  a_r8_fix_seq: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && resolve_mispredict && !resolve_taken) |=> next_pc == $past(resolve_pc) + STEP);

  a_r4_seq_on_miss: assert property (@(posedge clk) disable iff (rst)
    !(resolve_valid && resolve_mispredict) |=> (btb_hit || next_pc == $past(fetch_pc) + STEP));

  a_r4_seq_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!(resolve_valid && resolve_mispredict) && !dir_taken) |=> next_pc == $past(fetch_pc) + STEP);

  a_r1_miss_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!btb_hit && !flush));

endmodule

bind fetch_target_unit fta_checker #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) chk_i (
  .clk                (clk),
  .rst                (rst),
  .fetch_pc           (fetch_pc),
  .dir_taken          (dir_taken),
  .resolve_valid      (resolve_valid),
  .resolve_pc         (resolve_pc),
  .resolve_target     (resolve_target),
  .resolve_taken      (resolve_taken),
  .resolve_mispredict (resolve_mispredict),
  .next_pc            (next_pc),
  .btb_hit            (btb_hit),
  .flush              (flush)
);

// File: tb/fetch_target_unit_tb.sv
`timescale 1ns/1ps
module fetch_target_unit_tb_top;

  localparam int AW = 32;
  localparam int NE = 16;
  localparam int IB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_pc = '0;
  logic          dir_taken = 1'b0;
  logic          rv = 1'b0;
  logic [AW-1:0] rpc = '0;
  logic [AW-1:0] rtgt = '0;
  logic          rtk = 1'b0;
  logic          rmp = 1'b0;
  logic [AW-1:0] next_pc;
  logic          btb_hit;
  logic          flush;

  int checks = 0;
  int errors = 0;

  // behavioural model: one slot per index, holding the branch address line and its target
  bit            m_vld  [NE];
  longint        m_line [NE];
  logic [AW-1:0] m_tgt  [NE];

  always #2 clk = ~clk;

  fetch_target_unit #(.ADDR_W(AW), .ENTRIES(NE), .INSN_BYTES(IB)) dut_i (
    .clk                (clk),
    .rst                (rst),
    .fetch_pc           (fetch_pc),
    .dir_taken          (dir_taken),
    .resolve_valid      (rv),
    .resolve_pc         (rpc),
    .resolve_target     (rtgt),
    .resolve_taken      (rtk),
    .resolve_mispredict (rmp),
    .next_pc            (next_pc),
    .btb_hit            (btb_hit),
    .flush              (flush)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: predict from the model, advance the model, compare after the edge
  task automatic step(string req);
    int slot, wslot;
    bit h;
    logic [AW-1:0] e_npc;
    bit e_hit, e_fl;
    if (rst) begin
      for (int k = 0; k < NE; k++) m_vld[k] = 0;
      e_npc = '0; e_hit = 0; e_fl = 0;
    end else begin
      slot = int'((fetch_pc / IB) % NE);
      h = m_vld[slot] && (m_line[slot] == longint'(fetch_pc / (IB * NE)));
      e_hit = h;
      if (rv && rmp) begin
        e_fl = 1;
        e_npc = rtk ? rtgt : rpc + IB;
      end else begin
        e_fl = 0;
        e_npc = (h && dir_taken) ? m_tgt[slot] : fetch_pc + IB;
      end
      if (rv && rtk) begin
        wslot = int'((rpc / IB) % NE);
        m_vld[wslot] = 1;
        m_line[wslot] = longint'(rpc / (IB * NE));
        m_tgt[wslot] = rtgt;
      end
    end
    @(posedge clk);
    #1;
    chk(req, "next_pc", longint'(next_pc), longint'(e_npc));
    chk(req, "btb_hit", longint'(btb_hit), longint'(e_hit));
    chk(req, "flush",   longint'(flush),   longint'(e_fl));
  endtask

  task automatic drive(logic [AW-1:0] pc, logic dt, logic v, logic [AW-1:0] bpc,
                       logic [AW-1:0] tg, logic tk, logic mp);
    fetch_pc = pc; dir_taken = dt; rv = v; rpc = bpc; rtgt = tg; rtk = tk; rmp = mp;
  endtask

  task automatic look(string req, logic [AW-1:0] pc, logic dt);
    drive(pc, dt, 1'b0, '0, '0, 1'b0, 1'b0);
    step(req);
  endtask

  task automatic learn(string req, logic [AW-1:0] bpc, logic [AW-1:0] tg);
    drive(32'h0000_8000, 1'b0, 1'b1, bpc, tg, 1'b1, 1'b0);
    step(req);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    // R1: reset state
    for (int k = 0; k < 3; k++) step("R1");
    rst = 1'b0;
    // R1: everything misses after reset, R4 sequential path
    look("R1", 32'h0000_0100, 1'b1);
    look("R1", 32'h0000_0040, 1'b1);
    look("R4", 32'h0000_0200, 1'b0);

    // R6: learn a taken branch, then R4 select by direction
    learn("R6", 32'h0000_0100, 32'h0000_2000);
    look("R6", 32'h0000_0100, 1'b1);
    look("R4", 32'h0000_0100, 1'b0);
    // R3: low bits ignored, same index with other tag misses
    look("R3", 32'h0000_0102, 1'b1);
    look("R3", 32'h0000_0140, 1'b1);
    look("R3", 32'h0000_0104, 1'b1);

    // R7: not-taken resolution changes nothing
    drive(32'h0000_0300, 1'b0, 1'b1, 32'h0000_0100, 32'h0000_7777, 1'b0, 1'b0);
    step("R7");
    look("R7", 32'h0000_0100, 1'b1);

    // R6: newer instance replaces target; alias evicts
    learn("R6", 32'h0000_0100, 32'h0000_3000);
    look("R6", 32'h0000_0100, 1'b1);
    learn("R6", 32'h0000_0140, 32'h0000_5000);
    look("R6", 32'h0000_0100, 1'b1);
    look("R6", 32'h0000_0140, 1'b1);

    // R8: mispredict while the lookup hits a taken entry
    drive(32'h0000_0140, 1'b1, 1'b1, 32'h0000_0600, 32'h0000_0A00, 1'b1, 1'b1);
    step("R8");
    drive(32'h0000_0140, 1'b1, 1'b1, 32'h0000_0700, 32'h0000_0B00, 1'b0, 1'b1);
    step("R8");
    look("R8", 32'h0000_0140, 1'b1);

    // R10: resolve inputs ignored while resolve_valid is low
    drive(32'h0000_0900, 1'b1, 1'b0, 32'h0000_0900, 32'h0000_0C00, 1'b1, 1'b1);
    step("R10");
    look("R10", 32'h0000_0900, 1'b1);

    // R9: same-cycle update and lookup of one address
    drive(32'h0000_0A10, 1'b1, 1'b1, 32'h0000_0A10, 32'h0000_4400, 1'b1, 1'b0);
    step("R9");
    look("R9", 32'h0000_0A10, 1'b1);

    // R5: direction tied high
    learn("R5", 32'h0000_1008, 32'h0000_0020);
    learn("R5", 32'h0000_100C, 32'h0000_0030);
    for (int k = 0; k < 8; k++) look("R5", 32'h0000_1000 + 32'(k * 4), 1'b1);

    // R2: randomized mix over a narrow range, compared every clock
    for (int k = 0; k < 400; k++) begin
      drive(32'h0000_1000 + (32'($urandom % 48) << 2), 1'($urandom),
            1'($urandom), 32'h0000_1000 + (32'($urandom % 48) << 2),
            32'($urandom) & 32'hFFFF_FFFC, 1'($urandom), 1'(($urandom % 4) == 0));
      step("R2");
    end

    // R1: reset again clears all entries
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    look("R1", 32'h0000_1008, 1'b1);
    look("R1", 32'h0000_0100, 1'b1);

    finish_run();
  end

endmodule